// File: doc/BRIEF.md
# Dual-Register Phase Accumulator Oscillator

This block is a numerically controlled oscillator built around a 28-bit phase accumulator. Two frequency tuning words and two 12-bit phase offsets are presented on its pins by a control-word receiver elsewhere in the chip. One select pin picks which tuning word is added to the accumulator on each clock. A second select pin picks which offset is added to the upper accumulator bits. The output frequency is the tuning word times the clock frequency divided by 2^28. In the offset, 4096 stands for one full turn.

The block produces a 12-bit phase word for a downstream waveform lookup, marked by a valid flag. It also drives a one-bit square-wave output with its own output-enable, so the pad can be tri-stated outside the block. Three flags shape the run:
- A hold flag clears the accumulator and keeps it at zero.
- A halt flag freezes the accumulator.
- A power-down flag withdraws the phase stream while the accumulator keeps running.

The phase stream is valid-only and has no back-pressure. A sample is produced on every clock in which `out_valid` is high, and the consumer must accept it in that cycle.

Top module: `nco_dual_reg`

## Requirements
- R1: When neither hold nor halt is set, the accumulator grows by the selected tuning word on every clock edge and wraps modulo 2^28.
- R2: `freq_sel` = 0 selects `freq0` and `freq_sel` = 1 selects `freq1`. A change of select applies from the next edge without disturbing the accumulated phase.
- R3: `out_phase` shows, one edge later, accumulator bits [27:16] plus the selected phase offset, modulo 4096.
- R4: `phase_sel` = 0 selects `phase0` and `phase_sel` = 1 selects `phase1`.
- R5: While `hold_reset` is high, the accumulator is held at zero and `out_valid` is low. After the flag is released, counting restarts from zero.
- R6: While `clk_halt` is high and `hold_reset` is low, the accumulator keeps its value, so `out_phase` stays constant for a fixed offset.
- R7: `pwr_down` drives `out_valid` low from the next edge, and the accumulator keeps advancing.
- R8: With `sign_en` low, `sign_oe` and `sign_out` are both 0.
- R9: With `sign_en`=1, `sign_div2`=0 and `sign_cmp`=0, `sign_out` is a toggle flop. It flips on the edge after the one that raises accumulator bit 27, so it runs at half the MSB rate. `hold_reset` clears it.
- R10: With `sign_en`=1 and `sign_div2`=1, `sign_out` equals accumulator bit 27, whatever the value of `sign_cmp`.
- R11: The combination `sign_en`=1, `sign_div2`=0, `sign_cmp`=1 is reserved and gives `sign_oe`=0 and `sign_out`=0.
- R12: A low `rst_n` at a clock edge clears the accumulator, the toggle flop, `out_phase` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| freq0 | input | 28 | Tuning word A |
| freq1 | input | 28 | Tuning word B |
| phase0 | input | 12 | Phase offset A |
| phase1 | input | 12 | Phase offset B |
| freq_sel | input | 1 | Tuning word select |
| phase_sel | input | 1 | Phase offset select |
| hold_reset | input | 1 | Hold the accumulator at zero and suppress output |
| clk_halt | input | 1 | Freeze the accumulator |
| pwr_down | input | 1 | Suppress the phase stream |
| sign_en | input | 1 | Enable the square-wave output |
| sign_div2 | input | 1 | Square-wave mode bit: 1 = MSB directly |
| sign_cmp | input | 1 | Square-wave mode bit: comparator slot |
| out_phase | output | 12 | Phase word for the lookup |
| out_valid | output | 1 | Phase word valid |
| sign_out | output | 1 | Square-wave data |
| sign_oe | output | 1 | Square-wave output enable |

## Verification
Timing from a stimulus to its results:
- Control and data pins are set between edges.
- `out_phase` and `out_valid` reflect them one rising edge later.
- `sign_out` reflects the accumulator value loaded at that same edge, combined with the mode pins as currently driven.
- The toggle mode lags a rise of bit 27 by one further edge.

The driver advances a bench-side model of the accumulator, toggle flop and pipeline register by exactly one edge per step and queues the predicted outputs. The monitor pops each prediction one time unit after the matching rising edge, so every comparison lands in the cycle where the result is due.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    SGN_OFF    = 2'd0,
    SGN_TOGGLE = 2'd1,
    SGN_MSB    = 2'd2
  } sgn_mode_e;

  function automatic sgn_mode_e decode_sign(input logic en, input logic div2, input logic cmp);
    if (!en)                 return SGN_OFF;
    else if (div2)           return SGN_MSB;    // comparator slot maps to MSB too
    else if (!cmp)           return SGN_TOGGLE;
    else                     return SGN_OFF;    // reserved combination
  endfunction
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             halt,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) acc <= '0;
    else if (!halt)      acc <= acc + step;
  end
endmodule

// File: rtl/nco_phase_out.sv
module nco_phase_out #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             quiet,
  input  logic [ACC_W-1:0] acc,
  input  logic [PH_W-1:0]  offset,
  output logic [PH_W-1:0]  phase,
  output logic             valid
);
  localparam int TOP_LSB = ACC_W - PH_W;

  logic [PH_W-1:0] sum;
  always_comb sum = acc[ACC_W-1:TOP_LSB] + offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      valid <= 1'b0;
    end else begin
      phase <= sum;
      valid <= !quiet;
    end
  end
endmodule

// File: rtl/nco_sign_gen.sv
module nco_sign_gen
  import nco_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic msb,
  input  logic en,
  input  logic div2,
  input  logic cmp,
  output logic sign_out,
  output logic sign_oe
);
  logic      prev_q, tog_q;
  sgn_mode_e mode;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prev_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      prev_q <= msb;
      if (msb && !prev_q) tog_q <= ~tog_q;
    end
  end

  always_comb begin
    mode = decode_sign(en, div2, cmp);
    unique case (mode)
      SGN_TOGGLE: begin sign_oe = 1'b1; sign_out = tog_q; end
      SGN_MSB:    begin sign_oe = 1'b1; sign_out = msb;   end
      default:    begin sign_oe = 1'b0; sign_out = 1'b0;  end
    endcase
  end
endmodule

// File: rtl/nco_dual_reg.sv
module nco_dual_reg #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq0,
  input  logic [ACC_W-1:0] freq1,
  input  logic [PH_W-1:0]  phase0,
  input  logic [PH_W-1:0]  phase1,
  input  logic             freq_sel,
  input  logic             phase_sel,
  input  logic             hold_reset,
  input  logic             clk_halt,
  input  logic             pwr_down,
  input  logic             sign_en,
  input  logic             sign_div2,
  input  logic             sign_cmp,
  output logic [PH_W-1:0]  out_phase,
  output logic             out_valid,
  output logic             sign_out,
  output logic             sign_oe
);
  logic [ACC_W-1:0] step_sel, acc_q;
  logic [PH_W-1:0]  off_sel;

  always_comb begin
    step_sel = freq_sel  ? freq1  : freq0;
    off_sel  = phase_sel ? phase1 : phase0;
  end

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(hold_reset), .halt(clk_halt),
    .step(step_sel), .acc(acc_q)
  );

  nco_phase_out #(.ACC_W(ACC_W), .PH_W(PH_W)) u_out (
    .clk(clk), .rst_n(rst_n), .quiet(hold_reset || pwr_down),
    .acc(acc_q), .offset(off_sel), .phase(out_phase), .valid(out_valid)
  );

  nco_sign_gen u_sign (
    .clk(clk), .rst_n(rst_n), .clear(hold_reset), .msb(acc_q[ACC_W-1]),
    .en(sign_en), .div2(sign_div2), .cmp(sign_cmp),
    .sign_out(sign_out), .sign_oe(sign_oe)
  );
endmodule

// File: rtl/nco_dual_reg_chk.sv
module nco_dual_reg_chk #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ACC_W-1:0] freq0,
  input logic [ACC_W-1:0] freq1,
  input logic             freq_sel,
  input logic             hold_reset,
  input logic             clk_halt,
  input logic             pwr_down,
  input logic             sign_en,
  input logic             sign_div2,
  input logic             sign_cmp,
  input logic [ACC_W-1:0] acc_q,
  input logic             out_valid,
  input logic             sign_out,
  input logic             sign_oe
);
  a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_reset && !clk_halt) |=> acc_q == $past(acc_q) + ($past(freq_sel) ? $past(freq1) : $past(freq0)));

  a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold_reset |=> (acc_q == '0 && !out_valid));

  a_r6_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_reset && clk_halt) |=> $stable(acc_q));

  a_r7_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !out_valid);

  a_r8_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sign_en |-> (!sign_oe && !sign_out));

  a_r10_msb_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (sign_en && sign_div2) |-> (sign_oe && sign_out == acc_q[ACC_W-1]));

  a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (sign_en && !sign_div2 && sign_cmp) |-> !sign_oe);
endmodule

bind nco_dual_reg nco_dual_reg_chk #(.ACC_W(ACC_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .freq0(freq0), .freq1(freq1), .freq_sel(freq_sel),
  .hold_reset(hold_reset), .clk_halt(clk_halt), .pwr_down(pwr_down),
  .sign_en(sign_en), .sign_div2(sign_div2), .sign_cmp(sign_cmp),
  .acc_q(acc_q), .out_valid(out_valid), .sign_out(sign_out), .sign_oe(sign_oe)
);

// File: tb/nco_dual_reg_test.sv
module nco_dual_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [27:0] freq0 = '0, freq1 = '0;
  logic [11:0] phase0 = '0, phase1 = '0;
  logic freq_sel = 0, phase_sel = 0, hold_reset = 0, clk_halt = 0, pwr_down = 0;
  logic sign_en = 0, sign_div2 = 0, sign_cmp = 0;
  logic [11:0] out_phase;
  logic out_valid, sign_out, sign_oe;

  always #2.5 clk = ~clk;

  nco_dual_reg uut (
    .clk(clk), .rst_n(rst_n), .freq0(freq0), .freq1(freq1), .phase0(phase0), .phase1(phase1),
    .freq_sel(freq_sel), .phase_sel(phase_sel), .hold_reset(hold_reset), .clk_halt(clk_halt),
    .pwr_down(pwr_down), .sign_en(sign_en), .sign_div2(sign_div2), .sign_cmp(sign_cmp),
    .out_phase(out_phase), .out_valid(out_valid), .sign_out(sign_out), .sign_oe(sign_oe)
  );

  typedef struct {
    logic [11:0] ph;
    logic        vld;
    logic        so;
    logic        oe;
    string       tag;
  } item_t;

  item_t q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench-side model
  logic [27:0] m_acc = '0;
  logic        m_prev = 0, m_tog = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock step with the inputs currently driven
  task automatic step(input string tag);
    item_t it;
    logic [11:0] off;
    logic [27:0] nacc;
    logic np, nt;
    off = phase_sel ? phase1 : phase0;
    it.ph  = m_acc[27:16] + off;
    it.vld = !(hold_reset || pwr_down);
    if (hold_reset) begin nacc = '0; np = 0; nt = 0; end
    else begin
      nacc = clk_halt ? m_acc : m_acc + (freq_sel ? freq1 : freq0);
      np = m_acc[27];
      nt = (m_acc[27] && !m_prev) ? ~m_tog : m_tog;
    end
    m_acc = nacc; m_prev = np; m_tog = nt;
    if (!sign_en)        begin it.oe = 0; it.so = 0; end
    else if (sign_div2)  begin it.oe = 1; it.so = m_acc[27]; end
    else if (!sign_cmp)  begin it.oe = 1; it.so = m_tog; end
    else                 begin it.oe = 0; it.so = 0; end
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        item_t e;
        #1;
        e = q.pop_front();
        chk(e.tag, "out_phase", out_phase, e.ph);
        chk(e.tag, "out_valid", out_valid, e.vld);
        chk(e.tag, "sign_out",  sign_out,  e.so);
        chk(e.tag, "sign_oe",   sign_oe,   e.oe);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "out_phase", out_phase, 0);
    chk("R12", "out_valid", out_valid, 0);
    chk("R12", "sign_oe", sign_oe, 0);
    rst_n = 1;
    // R1: plain accumulation with odd word
    freq0 = 28'h0123457; freq1 = 28'h2000000;
    for (int i = 0; i < 8; i++) step("R1");
    // R3/R4: offsets
    phase0 = 12'h800; phase1 = 12'h0FF;
    for (int i = 0; i < 4; i++) step("R3");
    phase_sel = 1;
    for (int i = 0; i < 4; i++) step("R4");
    // R2: switch tuning word, wraps modulo 2^28 (R1)
    freq_sel = 1;
    for (int i = 0; i < 12; i++) step("R2");
    freq_sel = 0;
    for (int i = 0; i < 3; i++) step("R2");
    // R6: halt
    clk_halt = 1;
    for (int i = 0; i < 4; i++) step("R6");
    clk_halt = 0;
    // R7: power-down
    pwr_down = 1;
    for (int i = 0; i < 4; i++) step("R7");
    pwr_down = 0;
    step("R7");
    // R5: hold then release
    hold_reset = 1; clk_halt = 1;
    for (int i = 0; i < 3; i++) step("R5");
    hold_reset = 0; clk_halt = 0;
    for (int i = 0; i < 3; i++) step("R5");
    // sign modes at 1/8 turn per cycle
    freq_sel = 1; phase_sel = 0;
    for (int i = 0; i < 5; i++) step("R8");
    sign_en = 1;
    for (int i = 0; i < 34; i++) step("R9");
    sign_div2 = 1;
    for (int i = 0; i < 12; i++) step("R10");
    sign_cmp = 1;
    for (int i = 0; i < 12; i++) step("R10");
    sign_div2 = 0;
    for (int i = 0; i < 6; i++) step("R11");
    // R9 again after a hold clears the toggle
    sign_cmp = 0; hold_reset = 1;
    step("R9");
    hold_reset = 0;
    for (int i = 0; i < 20; i++) step("R9");
    // R12: reset mid-run
    rst_n = 0;
    @(negedge clk);
    q.delete();
    @(negedge clk);
    chk("R12", "out_phase", out_phase, 0);
    chk("R12", "out_valid", out_valid, 0);
    chk("R12", "sign_out", sign_out, 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule